// File: doc/BRIEF.md
# Drop-on-Full Sink FIFO with Accepted-Word Counter

This block sits between a register-style write port, driven by a host link that cannot be paused, and a consumer in the application clock domain. Every word that the bus side presents is offered to a first-in first-out store. If no slot is free, the word is thrown away and the writer carries on without stalling. The consumer takes words through a valid/ready pop port.

Flow control comes from a counter of the words that were really stored. The host reads it as a read-only register, and each read sets it back to zero. The host sends a burst sized to the whole store, then reads the counter in the same transaction. The difference between the words it sent and the words the counter reports is the number it must resend in the next burst.

Top module: `dropFifoSink`

## Requirements
- R1: After reset the store is empty: `emptyFlag`=1, `fullFlag`=0, `popValid`=0 and `cntValue`=0.
- R2: Words that are accepted leave the pop port in the same order in which they were written.
- R3: `popValid` is high exactly when the store holds at least one word, and `popData` then shows the oldest word. A cycle with `popValid` and `popReady` both high removes that word at the clock edge.
- R4: `fullFlag` is high exactly when DEPTH words are held, and `emptyFlag` exactly when none are held. The two are never high together.
- R5: A write while the store is full and no pop happens in that cycle is discarded. Contents, flags and counter are left unchanged, and `wrValid` is never refused.
- R6: A write in the same cycle as a pop while the store is full is accepted, because the pop frees a slot in that cycle.
- R7: `cntValue` goes up by one for each accepted word and does not change for a discarded word or in an idle cycle.
- R8: `cntValue` shows the current count in the cycle where `cntRead` is high. After that edge the count is zero, unless R9 applies.
- R9: If `cntRead` and an accepted write fall in the same cycle, the read returns the old value and the count afterwards is 1.
- R10: The counter stops at its all-ones value (2^CNT_W-1) and does not wrap.
- R11: `popReady` while the store is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Bus write strobe for a data word |
| wrData | input | DATA_W | Bus write data |
| cntRead | input | 1 | Read strobe of the accepted-count register |
| cntValue | output | CNT_W | Accepted-count register value |
| popValid | output | 1 | Oldest word is available |
| popReady | input | 1 | Consumer takes the word |
| popData | output | DATA_W | Oldest stored word |
| fullFlag | output | 1 | Store holds DEPTH words |
| emptyFlag | output | 1 | Store holds no words |

## Verification
Two pairs of functions can fall in the same cycle. A bus write and a consumer pop can meet while the store is full. A counter read and an accepted write can also land on the same edge. Directed steps set up each collision on purpose: a full store with write and pop together, and a counter read issued together with a write that a pop lets through. Random traffic with frequent counter reads then produces many more of them. In every cycle the bench compares flags, output data and the count against a queue model and a counter model that follow the stated rules.

// File: rtl/dropFifoPkg.sv
package dropFifoPkg;
  // Strobes from control to storage for one clock edge
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobes_t;
endpackage

// File: rtl/dropFifoCtrl.sv
module dropFifoCtrl
  import dropFifoPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             cntRead,
  input  logic             popReady,
  output fifoStrobes_t     strb,
  output logic             fullFlag,
  output logic             emptyFlag,
  output logic             popValid,
  output logic [CNT_W-1:0] cntValue
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [LW-1:0]    level;
  logic [CNT_W-1:0] acceptCnt;
  logic             popFire;
  logic             accept;
  logic             atMax;

  assign emptyFlag = (level == '0);
  assign fullFlag  = (level == LW'(DEPTH));
  assign popValid  = !emptyFlag;
  assign popFire   = popReady && !emptyFlag;
  // a pop in the same cycle frees a slot for the incoming word
  assign accept    = wrValid && (!fullFlag || popFire);
  assign atMax     = &acceptCnt;
  assign cntValue  = acceptCnt;

  assign strb.push = accept;
  assign strb.pop  = popFire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level <= '0;
    end else begin
      case ({accept, popFire})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptCnt <= '0;
    end else if (cntRead) begin
      acceptCnt <= accept ? CNT_W'(1) : '0;
    end else if (accept && !atMax) begin
      acceptCnt <= acceptCnt + CNT_W'(1);
    end
  end

  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && !popReady) |=> fullFlag);

  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fullFlag && emptyFlag));

  // R11
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (emptyFlag && !wrValid) |=> emptyFlag);

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntRead && !wrValid) |=> (cntValue == '0));

  // R9
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntRead && wrValid && !fullFlag) |=> (cntValue == CNT_W'(1)));

  // R7
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cntRead && !wrValid) |=> $stable(cntValue));
endmodule

// File: rtl/dropFifoStore.sv
module dropFifoStore
  import dropFifoPkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] popData
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + AW'(1);
      if (strb.pop)  rdPtr <= rdPtr + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= wrData;
  end

  assign popData = mem[rdPtr];

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.push |=> $stable(wrPtr));
endmodule

// File: rtl/dropFifoSink.sv
module dropFifoSink
  import dropFifoPkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cntRead,
  output logic [CNT_W-1:0]  cntValue,
  output logic              popValid,
  input  logic              popReady,
  output logic [DATA_W-1:0] popData,
  output logic              fullFlag,
  output logic              emptyFlag
);
  fifoStrobes_t strb;

  dropFifoCtrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .cntRead(cntRead),
    .popReady(popReady), .strb(strb), .fullFlag(fullFlag),
    .emptyFlag(emptyFlag), .popValid(popValid), .cntValue(cntValue)
  );

  dropFifoStore #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .popData(popData)
  );
endmodule

// File: tb/dropFifoSink_tb.sv
module dropFifoSink_tb;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 0;
  logic              rstN = 0;
  logic              wrValid = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic              cntRead = 0;
  logic              popReady = 0;
  logic [CNT_W-1:0]  cntValue;
  logic              popValid;
  logic [DATA_W-1:0] popData;
  logic              fullFlag;
  logic              emptyFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DATA_W-1:0] q[$];
  int modelCnt = 0;

  always #2 clk = ~clk;

  dropFifoSink #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .cntRead(cntRead), .cntValue(cntValue), .popValid(popValid),
    .popReady(popReady), .popData(popData), .fullFlag(fullFlag),
    .emptyFlag(emptyFlag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // compare every output against the model
  task automatic chkAll();
    chk("R3 popValid", int'(popValid), int'(q.size() > 0));
    chk("R4 fullFlag", int'(fullFlag), int'(q.size() == DEPTH));
    chk("R4 emptyFlag", int'(emptyFlag), int'(q.size() == 0));
    chk("R7 cntValue", int'(cntValue), modelCnt);
    if (q.size() > 0) chk("R2 popData", int'(popData), int'(q[0]));
  endtask

  function automatic int nextCnt(input int c, input bit rd, input bit acc);
    if (rd) return acc ? 1 : 0;
    if (acc && c < CMAX) return c + 1;
    return c;
  endfunction

  // one cycle: drive at negedge, model at posedge, check at next negedge
  task automatic step(input bit wv, input logic [DATA_W-1:0] wd,
                      input bit rd, input bit pr);
    bit popFire, acc;
    wrValid = wv; wrData = wd; cntRead = rd; popReady = pr;
    if (rd) chk("R8 read value", int'(cntValue), modelCnt);
    popFire = pr && (q.size() > 0);
    acc = wv && ((q.size() < DEPTH) || popFire);
    @(posedge clk);
    if (popFire) void'(q.pop_front());
    if (acc) q.push_back(wd);
    modelCnt = nextCnt(modelCnt, rd, acc);
    @(negedge clk);
    wrValid = 0; cntRead = 0; popReady = 0;
    chkAll();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1
    chk("R1 emptyFlag", int'(emptyFlag), 1);
    chk("R1 fullFlag", int'(fullFlag), 0);
    chk("R1 popValid", int'(popValid), 0);
    chk("R1 cntValue", int'(cntValue), 0);

    // R11: pop on empty store
    step(0, '0, 0, 1);
    chk("R11 empty after pop", int'(emptyFlag), 1);

    for (int i = 0; i < DEPTH; i++) step(1, DATA_W'(16'h100 + i), 0, 0);
    chk("R4 full after DEPTH", int'(fullFlag), 1);
    chk("R7 count DEPTH", int'(cntValue), DEPTH);

    // R5: write into full store without pop
    step(1, 16'hDEAD, 0, 0);
    chk("R5 count unchanged", int'(cntValue), DEPTH);
    chk("R5 head unchanged", int'(popData), 16'h100);

    // R6: write and pop together while full
    step(1, 16'hBEEF, 0, 1);
    chk("R6 count", int'(cntValue), DEPTH + 1);
    chk("R6 still full", int'(fullFlag), 1);

    // R8: read clears
    step(0, '0, 1, 0);
    chk("R8 cleared", int'(cntValue), 0);

    // R9: read with accepted write
    step(1, 16'h0A0A, 1, 1);
    chk("R9 restart at 1", int'(cntValue), 1);

    // R10: saturation under continuous write+pop
    for (int i = 0; i < 20; i++) step(1, DATA_W'(16'h200 + i), 0, 1);
    chk("R10 saturated", int'(cntValue), CMAX);

    // drain and check order
    while (q.size() > 0) step(0, '0, 0, 1);
    chk("R4 empty after drain", int'(emptyFlag), 1);

    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 100) < 60, DATA_W'($urandom),
           ($urandom % 100) < 10, ($urandom % 100) < 45);
    end
    finish();
  end
endmodule